// File: doc/BRIEF.md
# Two-Port Ownership Flag Bank

This block keeps a small bank of ownership flags that two independent agents, a left port and a right port, use to agree on who may touch a shared resource at a given time. One example of such a resource is a region of a memory that both agents can reach. Each flag is held by at most one port. A port claims or gives up a flag by writing to it. It learns whether it holds the flag by reading it back.

Both ports are sampled on one clock and share one synchronous reset. A port only reaches the flags while its active-low select is low. Its 3-bit index picks one of the eight flags. Bit 0 of the write data tells a claim from a give-up.

A claim on a flag that the other port holds is not lost. It waits, and the flag passes to the waiting port on the clock edge that records the holder's release. When both ports claim the same free flag in the same cycle, a fixed priority settles the tie.

Top module: `dual_port_semaphore`

## Requirements
- R1: While reset is high, every flag becomes free and every waiting claim is cleared, and both read buses show 8'hFF on the cycle after.
- R2: A write with select low and data bit 0 equal to 0 claims the indexed flag. If that flag is free and uncontested, the writing port holds it from the next cycle on.
- R3: While a port's select is high, its write and read strobes have no effect on any flag or on its read bus.
- R4: The index of a port picks the flag that port accesses. Flag k is reached with index value k.
- R5: A read with select low loads the port's read bus on the next clock edge. The value is 8'h00 when that port held the indexed flag during the read cycle, and 8'hFF otherwise. The bus then holds that value until the next read.
- R6: No flag is ever held by both ports. Two reads of the same flag in one cycle never both return 8'h00.
- R7: A claim on a flag that the other port holds is kept waiting. When the holder writes data bit 0 equal to 1, the waiting port holds the flag from the next cycle on.
- R8: When both ports claim the same free flag in one cycle, the left port gets it and the right port's claim is kept waiting.
- R9: A release (data bit 0 equal to 1) from a port that neither holds nor waits for the flag has no effect.
- R10: A release from a port that is waiting for the flag withdraws its waiting claim.
- R11: Accesses by the two ports to different flags in the same cycle do not affect each other.
- R12: A claim by the port that already holds the flag has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_sel_n | input | 1 | Left port flag select, active low |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| l_idx | input | 3 | Left port flag index |
| l_wdata | input | 8 | Left port write data; bit 0: 0 claim, 1 release |
| l_rdata | output | 8 | Left port registered read result |
| r_sel_n | input | 1 | Right port flag select, active low |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_idx | input | 3 | Right port flag index |
| r_wdata | input | 8 | Right port write data; bit 0: 0 claim, 1 release |
| r_rdata | output | 8 | Right port registered read result |

## Verification
The assertions check the following on every cycle and for every flag:
- a waiting claim never belongs to the holder, and no claim waits on a free flag;
- the hand-over after a release goes to the waiting port;
- a tie on a free flag goes to the left port;
- a cancel and a stray release act as R10 and R9 require;
- a cycle with no write leaves all state unchanged;
- reads of the same flag in one cycle never both report ownership.

Only the bench scenarios can show that particular index values reach the intended flags. They also show that accesses to different flags in the same cycle do not interfere, and that a full claim, wait, hand-over and cancel sequence gives the expected read-back values.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   lwait;
        logic   rwait;
    } slot_t;

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
    input  logic                 sel_n,
    input  logic                 wr,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 wbit,
    output logic [NUM_FLAGS-1:0] req_vec,
    output logic [NUM_FLAGS-1:0] rel_vec
);
    logic [NUM_FLAGS-1:0] hit;
    logic                 wr_act;

    always_comb begin
        wr_act  = ~sel_n & wr;
        hit     = NUM_FLAGS'(1) << idx;
        req_vec = (wr_act && !wbit) ? hit : '0;
        rel_vec = (wr_act &&  wbit) ? hit : '0;
    end
endmodule

// File: rtl/sem_slot.sv
module sem_slot
    import sem_pkg::*;
(
    input  slot_t cur,
    input  logic  lreq,
    input  logic  lrel,
    input  logic  rreq,
    input  logic  rrel,
    output slot_t nxt
);
    logic   own_l, own_r, lw, rw;
    owner_e owner_mid;

    always_comb begin
        own_l     = (cur.owner == OWN_LEFT);
        own_r     = (cur.owner == OWN_RIGHT);
        owner_mid = cur.owner;
        if ((own_l && lrel) || (own_r && rrel)) begin
            owner_mid = OWN_NONE;
        end
        // a waiting claim survives unless withdrawn; a new claim waits unless already held
        lw = (cur.lwait & ~lrel) | (lreq & ~own_l);
        rw = (cur.rwait & ~rrel) | (rreq & ~own_r);

        nxt.owner = owner_mid;
        nxt.lwait = lw;
        nxt.rwait = rw;
        if (owner_mid == OWN_NONE) begin
            if (lw) begin
                nxt.owner = OWN_LEFT;
                nxt.lwait = 1'b0;
            end else if (rw) begin
                nxt.owner = OWN_RIGHT;
                nxt.rwait = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sem_readback.sv
module sem_readback #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS),
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_n,
    input  logic                 rd,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_FLAGS-1:0] owned,
    output logic [DATA_W-1:0]    rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (!sel_n && rd) begin
            rdata_d = owned[idx] ? '0 : '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '1;
        else     rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dual_port_semaphore.sv
module dual_port_semaphore
    import sem_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS),
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel_n,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel_n,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int FLAG_LAST = NUM_FLAGS - 1;

    slot_t [FLAG_LAST:0] slots_d, slots_q, slot_nxt;
    logic  [FLAG_LAST:0] l_req, l_rel, r_req, r_rel;
    logic  [FLAG_LAST:0] l_owned, r_owned;
    logic                unused_wbits;

    assign unused_wbits = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) i_dec_l (
        .sel_n(l_sel_n), .wr(l_wr), .idx(l_idx), .wbit(l_wdata[0]),
        .req_vec(l_req), .rel_vec(l_rel)
    );

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) i_dec_r (
        .sel_n(r_sel_n), .wr(r_wr), .idx(r_idx), .wbit(r_wdata[0]),
        .req_vec(r_req), .rel_vec(r_rel)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_slot
        sem_slot i_slot (
            .cur (slots_q[g]),
            .lreq(l_req[g]), .lrel(l_rel[g]),
            .rreq(r_req[g]), .rrel(r_rel[g]),
            .nxt (slot_nxt[g])
        );
        assign l_owned[g] = (slots_q[g].owner == OWN_LEFT);
        assign r_owned[g] = (slots_q[g].owner == OWN_RIGHT);
    end

    always_comb begin
        slots_d = slot_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) slots_q <= '0;
        else     slots_q <= slots_d;
    end

    sem_readback #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_rb_l (
        .clk(clk), .rst(rst), .sel_n(l_sel_n), .rd(l_rd), .idx(l_idx),
        .owned(l_owned), .rdata(l_rdata)
    );

    sem_readback #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_rb_r (
        .clk(clk), .rst(rst), .sel_n(r_sel_n), .rd(r_rd), .idx(r_idx),
        .owned(r_owned), .rdata(r_rdata)
    );
endmodule

// File: rtl/sem_chk.sv
module sem_chk
    import sem_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS),
    parameter int DATA_W    = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          l_sel_n,
    input logic                          l_wr,
    input logic                          l_rd,
    input logic [IDX_W-1:0]              l_idx,
    input logic                          l_wbit,
    input logic [DATA_W-1:0]             l_rdata,
    input logic                          r_sel_n,
    input logic                          r_wr,
    input logic                          r_rd,
    input logic [IDX_W-1:0]              r_idx,
    input logic                          r_wbit,
    input logic [DATA_W-1:0]             r_rdata,
    input slot_t [NUM_FLAGS-1:0]         slots
);
    logic l_wact, r_wact;
    assign l_wact = ~l_sel_n & l_wr;
    assign r_wact = ~r_sel_n & r_wr;

    // R1
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (slots == '0 && l_rdata == '1 && r_rdata == '1));

    // R3
    assert_no_write_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!l_wact && !r_wact) |=> $stable(slots));

    // R5
    assert_read_owned_R5: assert property (@(posedge clk) disable iff (rst)
        (!l_sel_n && l_rd && slots[l_idx].owner == OWN_LEFT) |=> (l_rdata == '0));

    assert_read_not_owned_R5: assert property (@(posedge clk) disable iff (rst)
        (!r_sel_n && r_rd && slots[r_idx].owner != OWN_RIGHT) |=> (r_rdata == '1));

    // R6
    assert_exclusive_read_R6: assert property (@(posedge clk) disable iff (rst)
        (!l_sel_n && l_rd && !r_sel_n && r_rd && l_idx == r_idx)
        |=> !(l_rdata == '0 && r_rdata == '0));

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        logic lreq_g, lrel_g, rreq_g, rrel_g;
        assign lreq_g = l_wact && !l_wbit && (l_idx == IDX_W'(g));
        assign lrel_g = l_wact &&  l_wbit && (l_idx == IDX_W'(g));
        assign rreq_g = r_wact && !r_wbit && (r_idx == IDX_W'(g));
        assign rrel_g = r_wact &&  r_wbit && (r_idx == IDX_W'(g));

        // R7
        assert_wait_consistent_R7: assert property (@(posedge clk) disable iff (rst)
            !(slots[g].owner == OWN_LEFT  && slots[g].lwait) &&
            !(slots[g].owner == OWN_RIGHT && slots[g].rwait) &&
            !(slots[g].owner == OWN_NONE  && (slots[g].lwait || slots[g].rwait)));

        assert_handover_to_right_R7: assert property (@(posedge clk) disable iff (rst)
            (slots[g].owner == OWN_LEFT && lrel_g && slots[g].rwait && !rrel_g)
            |=> (slots[g].owner == OWN_RIGHT));

        assert_handover_to_left_R7: assert property (@(posedge clk) disable iff (rst)
            (slots[g].owner == OWN_RIGHT && rrel_g && slots[g].lwait && !lrel_g)
            |=> (slots[g].owner == OWN_LEFT));

        // R8
        assert_tie_left_wins_R8: assert property (@(posedge clk) disable iff (rst)
            (slots[g].owner == OWN_NONE && lreq_g && rreq_g)
            |=> (slots[g].owner == OWN_LEFT && slots[g].rwait));

        // R9
        assert_stray_release_R9: assert property (@(posedge clk) disable iff (rst)
            (slots[g].owner == OWN_RIGHT && !slots[g].lwait && lrel_g && !rreq_g && !rrel_g)
            |=> $stable(slots[g]));

        // R10
        assert_cancel_wait_R10: assert property (@(posedge clk) disable iff (rst)
            (slots[g].lwait && lrel_g) |=> !slots[g].lwait);
    end
endmodule

bind dual_port_semaphore sem_chk #(
    .NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W)
) i_sem_chk (
    .clk(clk), .rst(rst),
    .l_sel_n(l_sel_n), .l_wr(l_wr), .l_rd(l_rd), .l_idx(l_idx),
    .l_wbit(l_wdata[0]), .l_rdata(l_rdata),
    .r_sel_n(r_sel_n), .r_wr(r_wr), .r_rd(r_rd), .r_idx(r_idx),
    .r_wbit(r_wdata[0]), .r_rdata(r_rdata),
    .slots(slots_q)
);

// File: tb/test_dual_port_semaphore.sv
module test_dual_port_semaphore;
    localparam int NV = 23;
    localparam logic [1:0] OP_IDLE = 2'd0;
    localparam logic [1:0] OP_REQ  = 2'd1;
    localparam logic [1:0] OP_REL  = 2'd2;
    localparam logic [1:0] OP_RD   = 2'd3;

    // fields: lop[13:12] lidx[11:9] rop[8:7] ridx[6:4] chk_l[3] own_l[2] chk_r[1] own_r[0]
    localparam logic [13:0] VEC [NV] = '{
        {OP_REQ,  3'd0, OP_IDLE, 3'd0, 4'b0000},
        {OP_RD,   3'd0, OP_RD,   3'd0, 4'b1110},
        {OP_IDLE, 3'd0, OP_REQ,  3'd0, 4'b0000},
        {OP_RD,   3'd0, OP_RD,   3'd0, 4'b1110},
        {OP_REL,  3'd0, OP_IDLE, 3'd0, 4'b0000},
        {OP_RD,   3'd0, OP_RD,   3'd0, 4'b1011},
        {OP_REQ,  3'd3, OP_REQ,  3'd3, 4'b0000},
        {OP_RD,   3'd3, OP_RD,   3'd3, 4'b1110},
        {OP_REL,  3'd3, OP_IDLE, 3'd0, 4'b0000},
        {OP_RD,   3'd3, OP_RD,   3'd3, 4'b1011},
        {OP_REQ,  3'd5, OP_REQ,  3'd6, 4'b0000},
        {OP_RD,   3'd5, OP_RD,   3'd6, 4'b1111},
        {OP_RD,   3'd6, OP_RD,   3'd5, 4'b1010},
        {OP_REL,  3'd6, OP_IDLE, 3'd0, 4'b0000},
        {OP_RD,   3'd6, OP_RD,   3'd6, 4'b1011},
        {OP_REQ,  3'd6, OP_IDLE, 3'd0, 4'b0000},
        {OP_REL,  3'd6, OP_IDLE, 3'd0, 4'b0000},
        {OP_IDLE, 3'd0, OP_REL,  3'd6, 4'b0000},
        {OP_RD,   3'd6, OP_RD,   3'd6, 4'b1010},
        {OP_REQ,  3'd5, OP_REQ,  3'd5, 4'b0000},
        {OP_RD,   3'd5, OP_RD,   3'd5, 4'b1110},
        {OP_REL,  3'd5, OP_IDLE, 3'd0, 4'b0000},
        {OP_RD,   3'd5, OP_RD,   3'd5, 4'b1011}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       l_sel_n = 1'b1, l_wr = 1'b0, l_rd = 1'b0;
    logic [2:0] l_idx = '0;
    logic [7:0] l_wdata = '0;
    logic [7:0] l_rdata;
    logic       r_sel_n = 1'b1, r_wr = 1'b0, r_rd = 1'b0;
    logic [2:0] r_idx = '0;
    logic [7:0] r_wdata = '0;
    logic [7:0] r_rdata;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dual_port_semaphore i_dual_port_semaphore (
        .clk(clk), .rst(rst),
        .l_sel_n(l_sel_n), .l_wr(l_wr), .l_rd(l_rd), .l_idx(l_idx),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel_n(r_sel_n), .r_wr(r_wr), .r_rd(r_rd), .r_idx(r_idx),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    function automatic string vec_tag(int v);
        case (v)
            1:       return "R2";
            3:       return "R7";
            5:       return "R7";
            7:       return "R8";
            9:       return "R8";
            11:      return "R11";
            12:      return "R4";
            14:      return "R9";
            18:      return "R10";
            20:      return "R12";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_port(bit left, logic [1:0] op, logic [2:0] idx);
        logic sn, w, r;
        logic [7:0] d;
        sn = (op == OP_IDLE);
        w  = (op == OP_REQ) || (op == OP_REL);
        r  = (op == OP_RD);
        d  = (op == OP_REL) ? 8'h01 : 8'hFE;
        if (left) begin
            l_sel_n = sn; l_wr = w; l_rd = r; l_idx = idx; l_wdata = d;
        end else begin
            r_sel_n = sn; r_wr = w; r_rd = r; r_idx = idx; r_wdata = d;
        end
    endtask

    task automatic cycle(logic [1:0] lop, logic [2:0] li, logic [1:0] rop, logic [2:0] ri);
        set_port(1'b1, lop, li);
        set_port(1'b0, rop, ri);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, every flag free on both sides
        for (int k = 0; k < 8; k++) begin
            cycle(OP_RD, 3'(k), OP_RD, 3'(k));
            check("R1", l_rdata, 8'hFF);
            check("R1", r_rdata, 8'hFF);
        end

        // R3: strobes with select high are ignored
        l_sel_n = 1'b1; l_wr = 1'b1; l_rd = 1'b0; l_idx = 3'd1; l_wdata = 8'hFE;
        r_sel_n = 1'b1; r_wr = 1'b1; r_rd = 1'b0; r_idx = 3'd2; r_wdata = 8'hFE;
        @(negedge clk);
        l_rd = 1'b1; r_rd = 1'b1; l_wr = 1'b0; r_wr = 1'b0;
        @(negedge clk);
        check("R3 deselected read keeps bus", l_rdata, 8'hFF);
        cycle(OP_RD, 3'd1, OP_RD, 3'd2);
        check("R3", l_rdata, 8'hFF);
        check("R3", r_rdata, 8'hFF);
        cycle(OP_RD, 3'd2, OP_RD, 3'd1);
        check("R3", l_rdata, 8'hFF);
        check("R3", r_rdata, 8'hFF);

        // table walk: R2 R4 R5 R6 R7 R8 R9 R10 R11 R12
        for (int v = 0; v < NV; v++) begin
            cycle(VEC[v][13:12], VEC[v][11:9], VEC[v][8:7], VEC[v][6:4]);
            if (VEC[v][3]) check(vec_tag(v), l_rdata, VEC[v][2] ? 8'h00 : 8'hFF);
            if (VEC[v][1]) check(vec_tag(v), r_rdata, VEC[v][0] ? 8'h00 : 8'hFF);
        end

        // R5: read bus holds between reads
        cycle(OP_IDLE, 3'd0, OP_IDLE, 3'd0);
        check("R5 hold", r_rdata, 8'h00);

        // R1: reset in the middle of use clears held flag 5
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 bus after reset", r_rdata, 8'hFF);
        cycle(OP_RD, 3'd5, OP_RD, 3'd5);
        check("R1", l_rdata, 8'hFF);
        check("R1", r_rdata, 8'hFF);

        cycle(OP_IDLE, 3'd0, OP_IDLE, 3'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule